// File: doc/BRIEF.md
# Credit-Gated Packet Source

This block sits at the producing end of a packet stream that feeds one downstream consumer. Outgoing packets arrive beat by beat on a streaming input and are held in a local store. A packet becomes eligible to leave only once its final beat is stored. It actually leaves only while the consumer still has room in its receive window, counted in whole packets.

The consumer reports progress by sending small flow-control packets back to the source. Each one carries its running total of packets consumed. The source keeps its own running total of packets launched, and the difference between the two totals (modulo 4096) is the number of packets in flight. Software programs the window size with a register write, and that write also restarts both totals.

When the store is full and the window is closed, so that nothing can drain, an arriving packet is discarded whole at this point and never further down the path. A wrap-around counter records each such discard.

Top module: `cfc_flow_src`

## Requirements
- R1: After reset, out_tvalid is low, in_tready is high, fc_tready is high and ovf_count is zero.
- R2: Every packet that is kept leaves on the output with the same beats, the same tlast position and the same order in which it was accepted.
- R3: No beat of a packet appears on the output before the packet's last beat (in_tlast high) has been accepted.
- R4: A packet's first beat is offered only while (sent - acked) mod 4096 is less than the window. Here sent counts first beats transferred on the output and acked is the latest value received from the consumer.
- R5: A flow-control packet is recognised by the bits of its first beat: bit 63 = 0, bit 62 = 1 and bit 60 = 0. Bits [11:0] of its second beat replace acked. A packet with any other pattern on those bits leaves acked unchanged.
- R6: A write with reg_stb high and reg_addr equal to WIN_ADDR (default 8'h10) loads reg_data[11:0] into the window and clears sent and acked to zero. A write to any other address has no effect.
- R7: If a beat arrives while the store is full, the window is closed and no output packet is in progress, the whole packet is discarded, including beats already stored. in_tready stays high through the packet, and ovf_count rises by exactly one.
- R8: If the store is full while the window is open or an output packet is in progress, in_tready is low until space frees.
- R9: Once out_tvalid is high it stays high, with out_tdata and out_tlast stable, until out_tready is high. A packet whose first beat has left is finished regardless of later acks.
- R10: fc_tready is always high, so flow-control packets are never stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_tdata | input | DW | Packet data from the producer |
| in_tlast | input | 1 | Last beat of an incoming packet |
| in_tvalid | input | 1 | Incoming beat valid |
| in_tready | output | 1 | Block accepts the incoming beat |
| out_tdata | output | DW | Packet data towards the consumer |
| out_tlast | output | 1 | Last beat of an outgoing packet |
| out_tvalid | output | 1 | Outgoing beat valid |
| out_tready | input | 1 | Consumer side accepts the beat |
| fc_tdata | input | 64 | Flow-control packet beat |
| fc_tlast | input | 1 | Last beat of a flow-control packet |
| fc_tvalid | input | 1 | Flow-control beat valid |
| fc_tready | output | 1 | Always high |
| reg_stb | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_data | input | 32 | Register write data |
| ovf_count | output | OVF_W | Count of packets discarded whole |

## Verification
The window check assumes that the window register is not rewritten while an output packet is waiting or moving. It also assumes that no incoming packet is longer than the store. The stimulus writes the window only after the scoreboard has drained or while the window is closed, and it keeps every packet at 12 beats or fewer against a 32-beat store. Acks are sent only as complete two-beat packets, so the first-beat/second-beat parse always starts from a packet boundary. The ovf_count step check relies on drops being at most one per cycle, which the one-packet-at-a-time input ensures.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CW = 12;
  typedef logic [CW-1:0] cnt_t;

  // packets in flight, modulo 2^CW
  function automatic cnt_t in_flight(cnt_t launched, cnt_t returned);
    return launched - returned;
  endfunction

  // first-beat type code for a flow-control packet: bits 63,62,60 = 0,1,0
  function automatic logic is_fc_hdr(logic [63:0] hdr);
    return (hdr[63] == 1'b0) && (hdr[62] == 1'b1) && (hdr[60] == 1'b0);
  endfunction
endpackage

// File: rtl/cfc_ack_rx.sv
module cfc_ack_rx
  import cfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] fc_tdata,
  input  logic        fc_tlast,
  input  logic        fc_tvalid,
  input  logic        clear,
  output cnt_t        acked,
  output logic        ack_upd
);
  logic at_first;
  logic take_next;

  assign ack_upd = fc_tvalid && !at_first && take_next && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_first  <= 1'b1;
      take_next <= 1'b0;
      acked     <= '0;
    end else begin
      if (fc_tvalid) begin
        at_first <= fc_tlast;
        if (at_first) take_next <= is_fc_hdr(fc_tdata) && !fc_tlast;
        else          take_next <= 1'b0;
      end
      if (clear)        acked <= '0;
      else if (ack_upd) acked <= fc_tdata[CW-1:0];
    end
  end
endmodule

// File: rtl/cfc_pkt_buf.sv
module cfc_pkt_buf #(
  parameter int DW    = 64,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          rewind,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          full,
  output logic          pkt_avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr, pkt_cnt;
  logic          commit, retire;

  assign commit    = wr_en && wr_last;
  assign retire    = rd_en && rd_last;
  assign full      = (wr_ptr - rd_ptr) == FULL_LVL;
  assign pkt_avail = pkt_cnt != '0;
  assign rd_data   = mem[rd_ptr[AW-1:0]][DW-1:0];
  assign rd_last   = mem[rd_ptr[AW-1:0]][DW];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      cm_ptr  <= '0;
      rd_ptr  <= '0;
      pkt_cnt <= '0;
    end else begin
      if (rewind)      wr_ptr <= cm_ptr;
      else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
      if (commit)      cm_ptr <= wr_ptr + 1'b1;
      if (rd_en)       rd_ptr <= rd_ptr + 1'b1;
      case ({commit, retire})
        2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
        2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end
endmodule

// File: rtl/cfc_credit_gate.sv
module cfc_credit_gate
  import cfc_pkg::*;
#(
  parameter logic [7:0]    WIN_ADDR = 8'h10,
  parameter logic [CW-1:0] WIN_RST  = 12'd4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_stb,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_data,
  input  cnt_t        acked,
  input  logic        pkt_avail,
  input  logic        rd_last,
  input  logic        out_tready,
  output logic        out_tvalid,
  output logic        beat_fire,
  output logic        hdr_fire,
  output logic        win_wr,
  output logic        credit_ok,
  output logic        busy,
  output cnt_t        sent,
  output cnt_t        window,
  output cnt_t        outstanding
);
  logic in_pkt;

  assign win_wr      = reg_stb && (reg_addr == WIN_ADDR);
  assign outstanding = in_flight(sent, acked);
  assign credit_ok   = outstanding < window;
  assign out_tvalid  = busy || (pkt_avail && credit_ok);
  assign beat_fire   = out_tvalid && out_tready;
  assign hdr_fire    = beat_fire && !in_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      busy   <= 1'b0;
      sent   <= '0;
      window <= WIN_RST;
    end else begin
      if (beat_fire)        in_pkt <= !rd_last;
      if (beat_fire && rd_last) busy <= 1'b0;
      else if (out_tvalid)      busy <= 1'b1;
      if (win_wr) begin
        sent   <= '0;
        window <= reg_data[CW-1:0];
      end else if (hdr_fire) begin
        sent   <= sent + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfc_flow_src.sv
module cfc_flow_src
  import cfc_pkg::*;
#(
  parameter int            DW       = 64,
  parameter int            DEPTH    = 32,
  parameter int            OVF_W    = 16,
  parameter logic [7:0]    WIN_ADDR = 8'h10,
  parameter logic [CW-1:0] WIN_RST  = 12'd4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    in_tdata,
  input  logic             in_tlast,
  input  logic             in_tvalid,
  output logic             in_tready,
  output logic [DW-1:0]    out_tdata,
  output logic             out_tlast,
  output logic             out_tvalid,
  input  logic             out_tready,
  input  logic [63:0]      fc_tdata,
  input  logic             fc_tlast,
  input  logic             fc_tvalid,
  output logic             fc_tready,
  input  logic             reg_stb,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_data,
  output logic [OVF_W-1:0] ovf_count
);
  // named internal events
  logic wr_en, rewind, drop_start, dropping;
  logic full, pkt_avail, beat_fire, hdr_fire, win_wr, credit_ok, busy, ack_upd;
  cnt_t acked, sent, window, outstanding;

  assign fc_tready = 1'b1;

  cfc_ack_rx u_ack (
    .clk(clk), .rst(rst), .fc_tdata(fc_tdata), .fc_tlast(fc_tlast),
    .fc_tvalid(fc_tvalid), .clear(win_wr), .acked(acked), .ack_upd(ack_upd)
  );

  cfc_pkt_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(in_tdata), .wr_last(in_tlast),
    .rewind(rewind), .rd_en(beat_fire), .rd_data(out_tdata), .rd_last(out_tlast),
    .full(full), .pkt_avail(pkt_avail)
  );

  cfc_credit_gate #(.WIN_ADDR(WIN_ADDR), .WIN_RST(WIN_RST)) u_gate (
    .clk(clk), .rst(rst), .reg_stb(reg_stb), .reg_addr(reg_addr), .reg_data(reg_data),
    .acked(acked), .pkt_avail(pkt_avail), .rd_last(out_tlast), .out_tready(out_tready),
    .out_tvalid(out_tvalid), .beat_fire(beat_fire), .hdr_fire(hdr_fire), .win_wr(win_wr),
    .credit_ok(credit_ok), .busy(busy), .sent(sent), .window(window),
    .outstanding(outstanding)
  );

  // ingress: store, stall, or discard the whole packet
  always_comb begin
    in_tready  = 1'b1;
    wr_en      = 1'b0;
    rewind     = 1'b0;
    drop_start = 1'b0;
    if (dropping) begin
      in_tready = 1'b1;
    end else if (!full) begin
      wr_en = in_tvalid;
    end else if (credit_ok || busy) begin
      in_tready = 1'b0;
    end else begin
      rewind     = in_tvalid;
      drop_start = in_tvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dropping  <= 1'b0;
      ovf_count <= '0;
    end else begin
      if (drop_start) begin
        dropping  <= !in_tlast;
        ovf_count <= ovf_count + 1'b1;
      end else if (dropping && in_tvalid && in_tlast) begin
        dropping  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfc_src_chk.sv
module cfc_src_chk
  import cfc_pkg::*;
#(
  parameter int DW    = 64,
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             out_tvalid,
  input logic             out_tready,
  input logic             out_tlast,
  input logic [DW-1:0]    out_tdata,
  input logic             hdr_fire,
  input logic             win_wr,
  input logic             busy,
  input logic             pkt_avail,
  input cnt_t             sent,
  input cnt_t             window,
  input cnt_t             outstanding,
  input logic [OVF_W-1:0] ovf_count
);
  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |=> out_tvalid);
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |=> $stable(out_tdata) && $stable(out_tlast));
  // R4
  window_gate_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |-> outstanding < window);
  // R4
  sent_step_chk: assert property (@(posedge clk) disable iff (rst)
    !hdr_fire && !win_wr |=> $stable(sent));
  // R3
  start_needs_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !busy |-> pkt_avail);
  // R7
  ovf_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovf_count == $past(ovf_count)) || (ovf_count == $past(ovf_count) + 1'b1));
endmodule

bind cfc_flow_src cfc_src_chk #(.DW(DW), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst(rst), .out_tvalid(out_tvalid), .out_tready(out_tready),
  .out_tlast(out_tlast), .out_tdata(out_tdata), .hdr_fire(hdr_fire), .win_wr(win_wr),
  .busy(busy), .pkt_avail(pkt_avail), .sent(sent), .window(window),
  .outstanding(outstanding), .ovf_count(ovf_count)
);

// File: tb/cfc_flow_src_tb.sv
`timescale 1ns/1ps
module cfc_flow_src_tb;
  localparam int DW = 64;
  localparam logic [7:0] WIN_ADDR = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] in_tdata = '0;
  logic in_tlast = 1'b0, in_tvalid = 1'b0, in_tready;
  logic [DW-1:0] out_tdata;
  logic out_tlast, out_tvalid, out_tready = 1'b1;
  logic [63:0] fc_tdata = '0;
  logic fc_tlast = 1'b0, fc_tvalid = 1'b0, fc_tready;
  logic reg_stb = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_data = '0;
  logic [15:0] ovf_count;

  int n_chk = 0, n_bad = 0;
  int rdy_mode = 0;
  int cyc = 0;
  logic [DW:0] exp_q[$];

  always #2.5 clk = ~clk;

  cfc_flow_src #(.DW(DW), .WIN_ADDR(WIN_ADDR)) u_dut (
    .clk(clk), .rst(rst), .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid),
    .in_tready(in_tready), .out_tdata(out_tdata), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .fc_tdata(fc_tdata),
    .fc_tlast(fc_tlast), .fc_tvalid(fc_tvalid), .fc_tready(fc_tready), .reg_stb(reg_stb),
    .reg_addr(reg_addr), .reg_data(reg_data), .ovf_count(ovf_count)
  );

  // output-ready pattern
  always begin
    @(posedge clk); #1;
    cyc++;
    case (rdy_mode)
      0: out_tready = 1'b1;
      1: out_tready = 1'b0;
      default: out_tready = (cyc % 3) != 0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare of each transferred beat (R2)
  always @(negedge clk) begin
    if (!rst && out_tvalid && out_tready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected beat", longint'(out_tdata), 0);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        check({out_tlast, out_tdata} == e, "R2 beat content", longint'(out_tdata), longint'(e[DW-1:0]));
      end
    end
  end

  // all tasks start and end just after a rising edge
  task automatic put_beat(input logic [DW-1:0] d, input logic l);
    in_tdata = d; in_tlast = l; in_tvalid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_tready) break;
    end
    @(posedge clk); #1;
    in_tvalid = 1'b0; in_tlast = 1'b0;
  endtask

  task automatic send_pkt(input int id, input int len, input bit keep);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] d;
      d = (DW'(id) << 32) | DW'(i);
      if (keep) exp_q.push_back({(i == len - 1), d});
      put_beat(d, i == len - 1);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
    reg_stb = 1'b1; reg_addr = a; reg_data = v;
    @(posedge clk); #1;
    reg_stb = 1'b0;
  endtask

  task automatic send_fc(input logic [63:0] hdr, input logic [11:0] cnt);
    fc_tvalid = 1'b1; fc_tdata = hdr; fc_tlast = 1'b0;
    @(posedge clk); #1;
    fc_tdata = 64'(cnt); fc_tlast = 1'b1;
    @(posedge clk); #1;
    fc_tvalid = 1'b0; fc_tlast = 1'b0;
  endtask

  // R5 encoding: bit62 set, bits 63 and 60 clear
  task automatic send_ack(input logic [11:0] cnt);
    send_fc(64'h4000_0000_0000_0000, cnt);
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (out_tvalid) seen = 1;
    end
    check(!seen, tag, seen, 0);
    @(posedge clk); #1;
  endtask

  task automatic wait_left(input int n, input string tag);
    bit ok = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (exp_q.size() == n) begin ok = 1; break; end
    end
    check(ok, tag, exp_q.size(), n);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_tvalid, "R1 out_tvalid after reset", out_tvalid, 0);
    check(in_tready, "R1 in_tready after reset", in_tready, 1);
    check(fc_tready, "R10 fc_tready after reset", fc_tready, 1);
    check(ovf_count == 0, "R1 ovf_count after reset", ovf_count, 0);
    @(posedge clk); #1;

    // window of two: third packet waits for an ack
    wr_reg(WIN_ADDR, 32'd2);
    send_pkt(1, 4, 1); send_pkt(2, 4, 1); send_pkt(3, 4, 1);
    wait_left(4, "R4 two packets pass");
    expect_idle(10, "R4 window full holds packet");
    check(exp_q.size() == 4, "R4 no beat leaked", exp_q.size(), 4);
    send_fc(64'h0, 12'd1);
    expect_idle(8, "R5 data-type packet on fc port ignored");
    send_ack(12'd1);
    wait_left(0, "R5 ack releases packet");

    // window rewrite clears counters
    send_pkt(4, 3, 1);
    expect_idle(8, "R4 still closed");
    wr_reg(WIN_ADDR + 8'd1, 32'd50);
    expect_idle(6, "R6 other address ignored");
    wr_reg(WIN_ADDR, 32'd2);
    wait_left(0, "R6 window write clears counters");

    // modulo 4096 in-flight arithmetic
    wr_reg(WIN_ADDR, 32'd2);
    send_ack(12'd4095);
    send_pkt(5, 2, 1); send_pkt(6, 5, 1);
    wait_left(5, "R4 one packet with 1 in flight");
    expect_idle(8, "R4 modulo count closes window");
    send_ack(12'd0);
    wait_left(0, "R5 ack value wraps modulo");

    // whole packet stored before release
    wr_reg(WIN_ADDR, 32'd100);
    for (int i = 0; i < 5; i++) exp_q.push_back({(i == 4), (DW'(7) << 32) | DW'(i)});
    for (int i = 0; i < 4; i++) begin
      put_beat((DW'(7) << 32) | DW'(i), 1'b0);
      expect_idle(3, "R3 partial packet held");
    end
    put_beat((DW'(7) << 32) | DW'(4), 1'b1);
    wait_left(0, "R3 packet released after last beat");

    // full store with open window stalls input; output holds under stall
    wr_reg(WIN_ADDR, 32'd100);
    rdy_mode = 1;
    for (int p = 0; p < 4; p++) send_pkt(10 + p, 8, 1);
    fork
      send_pkt(14, 4, 1);
      begin
        repeat (3) @(negedge clk);
        check(!in_tready, "R8 stall when full and window open", in_tready, 0);
        check(out_tvalid, "R9 valid held without ready", out_tvalid, 1);
        @(posedge clk); #1;
        rdy_mode = 2;
      end
    join
    wait_left(0, "R9 packets drained with toggling ready");
    rdy_mode = 0;

    // whole-packet drop when full and window closed
    wr_reg(WIN_ADDR, 32'd1);
    send_pkt(20, 8, 1);
    wait_left(0, "R4 single packet sent");
    send_pkt(21, 8, 1); send_pkt(22, 8, 1); send_pkt(23, 8, 1);
    send_pkt(90, 12, 0);
    check(ovf_count == 1, "R7 partial packet dropped", ovf_count, 1);
    send_pkt(24, 8, 1);
    send_pkt(91, 4, 0);
    check(ovf_count == 2, "R7 packet dropped at first beat", ovf_count, 2);
    expect_idle(5, "R4 closed while store full");
    for (int a = 1; a <= 4; a++) begin
      send_ack(12'(a));
      repeat (14) @(posedge clk);
      #1;
    end
    wait_left(0, "R7 kept packets intact after rewind");
    check(ovf_count == 2, "R7 count unchanged by acks", ovf_count, 2);
    check(fc_tready, "R10 fc_tready stays high", fc_tready, 1);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule